// File: doc/BRIEF.md
# Full-Speed USB Host Frame Timer

This block sets the frame rhythm for a full-speed USB host controller. A 12 MHz bit-time enable drives it. Every 12000 bit ticks it requests a start-of-frame (SOF) packet from the transmitter and advances an 11-bit frame number. The last part of each frame is a programmable guard window, the end-of-frame (EOF) time. No new token may start inside that window, so a transaction that has begun always ends before the next SOF. Software should program the EOF time longer than the longest packet.

Software places a token request with the block. The block holds that request until the packet engine is idle and enough of the frame remains, then issues a one-cycle launch grant. If the request is still waiting when the frame boundary arrives, a mode bit decides what happens. In one mode the request is dropped and a sticky cancel flag is raised together with the SOF. In the other mode the request is carried over and launched early in the next frame. A token of the SOF kind makes the block emit an extra SOF request on demand. That SOF does not advance the frame number and does not raise the SOF flag.

Three sticky flags feed one interrupt output: SOF, token cancelled and packet complete. The SOF flag can be limited to frames whose low frame-number bits equal a compare value. Each flag is cleared by a one-cycle clear pulse, and a set event in the same cycle takes priority over the clear.

Top module: `usbh_frame_timer`

## Requirements
- R1: After every TICKS_PER_FRAME bit ticks counted from reset or from the last timed SOF, `sof_req` is high for exactly one cycle, in the cycle after the final tick. In that same cycle `frame_no` takes the value one higher, wrapping from 2047 to 0.
- R2: `eof_active` is high exactly when TICKS_PER_FRAME minus the number of ticks counted in the current frame is less than or equal to `eof_time`.
- R3: A waiting token is launched when three conditions hold together: `pkt_busy` is low, `eof_active` is low, and the current cycle is not the final tick of the frame. In the cycle after that, `tok_grant` (for a normal token) or `sof_req` (for an SOF-kind token) pulses for one cycle. Otherwise the token keeps waiting.
- R4: With `cancel_mode` = 1, a token still waiting at the final tick of a frame is dropped, and `tcan_flag` is set in the same cycle as the SOF request.
- R5: With `cancel_mode` = 0, a token still waiting at the final tick of a frame is kept, and it is launched in the next frame under R3.
- R6: `sof_flag` is set at a timed SOF if either of two conditions holds. The first is `step_en` = 0. The second is that the low CMP_W bits of the new `frame_no` equal `cmp_val`.
- R7: An SOF-kind token (`tok_sof` = 1 when `tok_req` pulses) produces a `sof_req` pulse that leaves `frame_no` unchanged and does not set `sof_flag`.
- R8: `irq` equals (`sof_flag` AND `sof_ie`) OR (`cmp_flag` AND `cmp_ie`).
- R9: A pulse on `clr_sof`, `clr_tcan` or `clr_cmp` clears the matching flag in the next cycle. If the flag's set event occurs in the same cycle, the flag stays set.
- R10: `cmp_flag` is set by a `pkt_done` pulse. A token cancellation never sets it.
- R11: While reset is low and in the first cycle after it is released, every output is 0. This includes `frame_no` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per 12 MHz bit time |
| eof_time | input | CNT_W | EOF guard window length, in bit ticks |
| step_en | input | 1 | Limits the SOF flag to frames that match the compare value |
| cmp_val | input | CMP_W | Compare value for the low frame-number bits |
| cancel_mode | input | 1 | 1: drop a token still waiting at the boundary; 0: carry it over |
| sof_ie | input | 1 | Interrupt enable for the SOF flag |
| cmp_ie | input | 1 | Interrupt enable for the packet-complete flag |
| tok_req | input | 1 | Pulse: software places a token |
| tok_sof | input | 1 | Kind of the placed token (1 = SOF) |
| pkt_busy | input | 1 | Packet engine is busy |
| pkt_done | input | 1 | Pulse: packet finished |
| clr_sof | input | 1 | Clear pulse for `sof_flag` |
| clr_tcan | input | 1 | Clear pulse for `tcan_flag` |
| clr_cmp | input | 1 | Clear pulse for `cmp_flag` |
| sof_req | output | 1 | Pulse: send an SOF packet |
| frame_no | output | FRAME_W | Current frame number |
| eof_active | output | 1 | Guard window is active |
| tok_grant | output | 1 | Pulse: launch the waiting token |
| sof_flag | output | 1 | Sticky SOF flag |
| tcan_flag | output | 1 | Sticky token-cancelled flag |
| cmp_flag | output | 1 | Sticky packet-complete flag |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a token that is still waiting at the exact final tick of a frame. To get there, a token must be placed inside the guard window, or the packet engine must be held busy across the boundary. A second hard case is a clear pulse that lands on the same edge as a timed SOF. The stimulus mixes random token writes, long busy periods and random EOF lengths with a directed phase. The directed phase places a token three ticks before the boundary, alternates the cancel mode from frame to frame, and fires `clr_sof` on every boundary tick. It keeps running until the frame number has wrapped past 2047.

// File: rtl/usbh_ft_pkg.sv
package usbh_ft_pkg;
  localparam int FLAG_N = 3;
  typedef enum int {
    FLG_SOF  = 0,
    FLG_TCAN = 1,
    FLG_CMP  = 2
  } flag_idx_e;
endpackage

// File: rtl/usbh_ft_frame_cnt.sv
module usbh_ft_frame_cnt #(
  parameter int TICKS_PER_FRAME = 12000,
  parameter int FRAME_W         = 11,
  parameter int CNT_W           = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               man_sof,
  input  logic [CNT_W-1:0]   eof_time,
  output logic               sof_evt,
  output logic [FRAME_W-1:0] next_frame,
  output logic [FRAME_W-1:0] frame_no,
  output logic               sof_req,
  output logic               eof_active
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_FRAME - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TICKS_PER_FRAME);

  logic [CNT_W-1:0]   tick_q, tick_d, remaining;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               sof_req_q, sof_req_d;

  always_comb begin
    sof_evt    = bit_tick && (tick_q == LAST);
    next_frame = frame_q + FRAME_W'(1);
    tick_d     = tick_q;
    if (bit_tick) begin
      tick_d = sof_evt ? '0 : tick_q + CNT_W'(1);
    end
    frame_d    = sof_evt ? next_frame : frame_q;
    sof_req_d  = sof_evt || man_sof;
    remaining  = FULL - tick_q;
    eof_active = (remaining <= eof_time);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q    <= '0;
      frame_q   <= '0;
      sof_req_q <= 1'b0;
    end else begin
      tick_q    <= tick_d;
      frame_q   <= frame_d;
      sof_req_q <= sof_req_d;
    end
  end

  assign frame_no = frame_q;
  assign sof_req  = sof_req_q;
endmodule

// File: rtl/usbh_ft_token_gate.sv
module usbh_ft_token_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tok_req,
  input  logic tok_sof,
  input  logic cancel_mode,
  input  logic pkt_busy,
  input  logic eof_active,
  input  logic sof_evt,
  output logic man_sof,
  output logic tok_cancel,
  output logic tok_grant
);
  logic pend_q, pend_d;
  logic kind_q, kind_d;
  logic grant_q, grant_d;
  logic go;

  always_comb begin
    go         = pend_q && !pkt_busy && !eof_active && !sof_evt;
    tok_cancel = pend_q && sof_evt && cancel_mode;
    man_sof    = go && kind_q;
    grant_d    = go && !kind_q;
    pend_d     = pend_q;
    kind_d     = kind_q;
    if (tok_req) begin
      pend_d = 1'b1;
      kind_d = tok_sof;
    end else if (go || tok_cancel) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      kind_q  <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      kind_q  <= kind_d;
      grant_q <= grant_d;
    end
  end

  assign tok_grant = grant_q;
endmodule

// File: rtl/usbh_ft_flag.sv
module usbh_ft_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic q_r, q_d;

  always_comb begin
    q_d = q_r;
    if (set_i)      q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/usbh_frame_timer.sv
module usbh_frame_timer #(
  parameter int TICKS_PER_FRAME = 12000,
  parameter int FRAME_W         = 11,
  parameter int CMP_W           = 4,
  parameter int CNT_W           = $clog2(TICKS_PER_FRAME + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic [CNT_W-1:0]   eof_time,
  input  logic               step_en,
  input  logic [CMP_W-1:0]   cmp_val,
  input  logic               cancel_mode,
  input  logic               sof_ie,
  input  logic               cmp_ie,
  input  logic               tok_req,
  input  logic               tok_sof,
  input  logic               pkt_busy,
  input  logic               pkt_done,
  input  logic               clr_sof,
  input  logic               clr_tcan,
  input  logic               clr_cmp,
  output logic               sof_req,
  output logic [FRAME_W-1:0] frame_no,
  output logic               eof_active,
  output logic               tok_grant,
  output logic               sof_flag,
  output logic               tcan_flag,
  output logic               cmp_flag,
  output logic               irq
);
  import usbh_ft_pkg::*;

  logic               sof_evt, man_sof, tok_cancel, step_hit;
  logic [FRAME_W-1:0] next_frame;
  logic [FLAG_N-1:0]  flag_set, flag_clr, flag_q;

  usbh_ft_frame_cnt #(
    .TICKS_PER_FRAME(TICKS_PER_FRAME),
    .FRAME_W        (FRAME_W),
    .CNT_W          (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .man_sof   (man_sof),
    .eof_time  (eof_time),
    .sof_evt   (sof_evt),
    .next_frame(next_frame),
    .frame_no  (frame_no),
    .sof_req   (sof_req),
    .eof_active(eof_active)
  );

  usbh_ft_token_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_req    (tok_req),
    .tok_sof    (tok_sof),
    .cancel_mode(cancel_mode),
    .pkt_busy   (pkt_busy),
    .eof_active (eof_active),
    .sof_evt    (sof_evt),
    .man_sof    (man_sof),
    .tok_cancel (tok_cancel),
    .tok_grant  (tok_grant)
  );

  always_comb begin
    step_hit           = (next_frame[CMP_W-1:0] == cmp_val);
    flag_set           = '0;
    flag_set[FLG_SOF]  = sof_evt && (!step_en || step_hit);
    flag_set[FLG_TCAN] = tok_cancel;
    flag_set[FLG_CMP]  = pkt_done;
    flag_clr           = '0;
    flag_clr[FLG_SOF]  = clr_sof;
    flag_clr[FLG_TCAN] = clr_tcan;
    flag_clr[FLG_CMP]  = clr_cmp;
  end

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    usbh_ft_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(flag_set[g]),
      .clr_i(flag_clr[g]),
      .q    (flag_q[g])
    );
  end

  assign sof_flag  = flag_q[FLG_SOF];
  assign tcan_flag = flag_q[FLG_TCAN];
  assign cmp_flag  = flag_q[FLG_CMP];
  assign irq       = (sof_flag && sof_ie) || (cmp_flag && cmp_ie);
endmodule

// File: rtl/usbh_ft_checker.sv
module usbh_ft_checker #(
  parameter int FRAME_W = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sof_req,
  input logic [FRAME_W-1:0] frame_no,
  input logic               eof_active,
  input logic               tok_grant,
  input logic               sof_flag,
  input logic               tcan_flag,
  input logic               cmp_flag,
  input logic               irq
);
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_no) |-> (sof_req && frame_no == FRAME_W'($past(frame_no) + FRAME_W'(1)))); // R1
  AST_GRANT_OUTSIDE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    tok_grant |-> $past(!eof_active)); // R3
  AST_GRANT_NOT_WITH_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    !(tok_grant && sof_req)); // R3
  AST_CANCEL_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tcan_flag) |-> (sof_req && !$stable(frame_no))); // R4
  AST_SOF_FLAG_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sof_flag) |-> (sof_req && !$stable(frame_no))); // R6
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sof_flag || cmp_flag)); // R8
endmodule

bind usbh_frame_timer usbh_ft_checker #(.FRAME_W(FRAME_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sof_req   (sof_req),
  .frame_no  (frame_no),
  .eof_active(eof_active),
  .tok_grant (tok_grant),
  .sof_flag  (sof_flag),
  .tcan_flag (tcan_flag),
  .cmp_flag  (cmp_flag),
  .irq       (irq)
);

// File: tb/tb_usbh_frame_timer.sv
module tb_usbh_frame_timer;
  localparam int TICKS = 32;
  localparam int FW    = 11;
  localparam int CW    = 4;
  localparam int NW    = $clog2(TICKS + 1);

  logic clk, rst_n;
  logic bit_tick, step_en, cancel_mode, sof_ie, cmp_ie;
  logic tok_req, tok_sof, pkt_busy, pkt_done, clr_sof, clr_tcan, clr_cmp;
  logic [NW-1:0] eof_time;
  logic [CW-1:0] cmp_val;
  logic sof_req, eof_active, tok_grant, sof_flag, tcan_flag, cmp_flag, irq;
  logic [FW-1:0] frame_no;

  int checks = 0, errs = 0;
  bit done = 0;

  // bench model state
  int       m_tick;
  bit [FW-1:0] m_frame;
  bit m_sofreq, m_grant, m_pend, m_psof, m_sof, m_tcan, m_cmp;
  bit seen_top, wrap_seen, seen_cancel, seen_defer;

  usbh_frame_timer #(.TICKS_PER_FRAME(TICKS), .FRAME_W(FW), .CMP_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .eof_time(eof_time),
    .step_en(step_en), .cmp_val(cmp_val), .cancel_mode(cancel_mode),
    .sof_ie(sof_ie), .cmp_ie(cmp_ie), .tok_req(tok_req), .tok_sof(tok_sof),
    .pkt_busy(pkt_busy), .pkt_done(pkt_done), .clr_sof(clr_sof),
    .clr_tcan(clr_tcan), .clr_cmp(clr_cmp), .sof_req(sof_req),
    .frame_no(frame_no), .eof_active(eof_active), .tok_grant(tok_grant),
    .sof_flag(sof_flag), .tcan_flag(tcan_flag), .cmp_flag(cmp_flag), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d (time %0t)", tag, got, exp, $time);
    end
  endtask

  function automatic bit exp_eof();
    return (TICKS - m_tick) <= int'(eof_time);
  endfunction

  function automatic bit exp_irq();
    return (m_sof && sof_ie) || (m_cmp && cmp_ie);
  endfunction

  task automatic compare_all();
    chk("R1 frame_no", int'(frame_no), int'(m_frame));
    chk("R1 R7 sof_req", int'(sof_req), int'(m_sofreq));
    chk("R2 eof_active", int'(eof_active), int'(exp_eof()));
    chk("R3 R5 tok_grant", int'(tok_grant), int'(m_grant));
    chk("R6 R9 sof_flag", int'(sof_flag), int'(m_sof));
    chk("R4 R9 tcan_flag", int'(tcan_flag), int'(m_tcan));
    chk("R10 R9 cmp_flag", int'(cmp_flag), int'(m_cmp));
    chk("R8 irq", int'(irq), int'(exp_irq()));
  endtask

  // advance the model by one clock edge with the inputs currently driven
  task automatic model_step();
    bit meof, sofe, go, canc, sset;
    bit [FW-1:0] nf;
    meof = exp_eof();
    sofe = bit_tick && (m_tick == TICKS - 1);
    go   = m_pend && !pkt_busy && !meof && !sofe;
    canc = m_pend && sofe && cancel_mode;
    nf   = m_frame + 1'b1;
    sset = sofe && (!step_en || nf[CW-1:0] == cmp_val);
    if (m_pend && sofe && !cancel_mode) seen_defer = 1;
    if (canc) seen_cancel = 1;
    m_sofreq = sofe || (go && m_psof);
    m_grant  = go && !m_psof;
    if (tok_req) begin
      m_pend = 1; m_psof = tok_sof;
    end else if (go || canc) begin
      m_pend = 0;
    end
    m_sof  = sset ? 1'b1 : (clr_sof  ? 1'b0 : m_sof);
    m_tcan = canc ? 1'b1 : (clr_tcan ? 1'b0 : m_tcan);
    m_cmp  = pkt_done ? 1'b1 : (clr_cmp ? 1'b0 : m_cmp);
    if (bit_tick) m_tick = sofe ? 0 : m_tick + 1;
    if (sofe) m_frame = nf;
  endtask

  task automatic pulses_off();
    tok_req = 0; tok_sof = 0; pkt_done = 0;
    clr_sof = 0; clr_tcan = 0; clr_cmp = 0;
  endtask

  task automatic step_and_check();
    model_step();
    @(negedge clk);
    compare_all();
    if (frame_no == 11'd2047) seen_top = 1;
    if (seen_top && frame_no == 11'd0) wrap_seen = 1;
    pulses_off();
  endtask

  initial begin
    void'($urandom(32'h5EED_0417));
    rst_n = 0; bit_tick = 0; step_en = 0; cancel_mode = 0; sof_ie = 0; cmp_ie = 0;
    pkt_busy = 0; eof_time = '0; cmp_val = '0;
    pulses_off();
    m_tick = 0; m_frame = '0;
    {m_sofreq, m_grant, m_pend, m_psof, m_sof, m_tcan, m_cmp} = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset sof_req", int'(sof_req), 0);
    chk("R11 reset frame_no", int'(frame_no), 0);
    chk("R11 reset tok_grant", int'(tok_grant), 0);
    chk("R11 reset flags", int'({sof_flag, tcan_flag, cmp_flag, irq}), 0);
    chk("R11 reset eof_active", int'(eof_active), 0);
    rst_n = 1;
    step_and_check();

    // random phase
    for (int i = 0; i < 20000; i++) begin
      if (i % 1500 == 0) begin
        cancel_mode = $urandom_range(0, 1);
        step_en     = $urandom_range(0, 1);
        cmp_val     = CW'($urandom_range(0, 15));
        eof_time    = NW'($urandom_range(2, 14));
        sof_ie      = $urandom_range(0, 1);
        cmp_ie      = $urandom_range(0, 1);
      end
      bit_tick = ($urandom_range(0, 3) != 0);
      if (($urandom_range(0, 15) == 0)) pkt_busy = ~pkt_busy;
      if (!m_pend && $urandom_range(0, 19) == 0) begin
        tok_req = 1; tok_sof = ($urandom_range(0, 7) == 0);
      end
      pkt_done = ($urandom_range(0, 59) == 0);
      clr_sof  = ($urandom_range(0, 29) == 0);
      clr_tcan = ($urandom_range(0, 29) == 0);
      clr_cmp  = ($urandom_range(0, 29) == 0);
      step_and_check();
    end

    // directed phase: boundary tokens, set-wins clears, frame wrap
    step_en = 1; cmp_val = 4'd5; eof_time = NW'(8); pkt_busy = 0;
    sof_ie = 1; cmp_ie = 0;
    for (int i = 0; i < 67000; i++) begin
      bit_tick    = 1;
      cancel_mode = m_frame[0];
      if (!m_pend && m_tick == TICKS - 3) tok_req = 1;       // inside guard, R4/R5
      if (m_tick == TICKS - 1) clr_sof = 1;                  // coincides with set, R9
      if (m_tick == 5) clr_tcan = 1;                         // R9 plain clear
      step_and_check();
    end

    chk("R1 frame number wrapped 2047 to 0", int'(wrap_seen), 1);
    chk("R4 cancel at boundary exercised", int'(seen_cancel), 1);
    chk("R5 carry-over at boundary exercised", int'(seen_defer), 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end
endmodule